// File: doc/BRIEF.md
# Packet-Committed Serial Endpoint Buffer

This block sits between a processor register port and a packet engine for a virtual serial link. It holds one buffer for each direction. To send, the processor pushes bytes one at a time through a 32-bit data word, of which only the low byte is kept. It then pulses a commit strobe. The committed packet is offered to the packet engine as a valid/ready byte stream, and the buffer stays closed to further processor writes until the engine has accepted the final beat.

To receive, the packet engine pushes a packet in as a valid/ready byte stream. Once the final beat lands, the packet is held until the processor has popped every byte. The receive write address starts at 2, so the payload length of a completed packet is that address minus 2. Three interrupt sources share a raw/enable/clear/status bank: packet received, transmit drained, and zero-payload packet received.

Both streams follow the usual rule: a beat moves on a rising clock edge where valid and ready are both high. On the transmit stream the block holds data and flags steady while it is stalled. On the receive stream, `out_ready` depends only on the receive state, never on `out_valid`.

Top module: `ser_ep_buffer`

## Requirements
- R1: A `cpu_wr` pulse stores `cpu_wdata[7:0]` at `tx_wr_addr` and advances it only while `tx_free` is 1. `tx_free` is 1 when no packet is committed and fewer than DEPTH bytes are loaded. Writes while it is 0 are ignored and change nothing.
- R2: A `cpu_done` pulse with `tx_free` state open commits every loaded byte, including one written in the same cycle. `tx_state` then reads 2 (committed) instead of 0 (open) and `tx_free` reads 0 until the last beat is accepted. Writes and commits made meanwhile are ignored.
- R3: While committed, `in_valid` is 1 and `in_data` presents the loaded bytes in order, one per accepted beat. `in_last` marks the final byte. Under a stall, data and flags hold. `in_data` reads 0 when there is no valid data byte.
- R4: A commit with no bytes loaded yields exactly one beat with `in_zlp`=1, `in_last`=1 and `in_data`=0.
- R5: Acceptance of the final transmit beat sets raw interrupt bit 1 (transmit drained). It also returns the transmit side to open with both addresses at 0.
- R6: `out_ready` is 1 in receive state 0 (open) and 1 (filling) and 0 in state 2 (held). An accepted beat with `out_zlp`=0 stores `out_data` in order. Bytes beyond the DEPTH-th of a packet are accepted and discarded.
- R7: `rx_wr_addr` equals 2 plus the number of stored bytes. When the last beat of a packet with at least one stored byte is accepted, raw bit 0 (packet received) sets and the state becomes held.
- R8: A packet that ends with no stored byte sets raw bit 2 (zero payload), leaves raw bit 0 alone and returns to open.
- R9: `rx_avail` is 1 when `rx_rd_addr` differs from `rx_wr_addr`. `cpu_rdata` then shows the oldest unread byte and a `cpu_rd` pulse pops it. With `rx_avail` at 0, `cpu_rdata` is 0 and `cpu_rd` moves nothing.
- R10: In the held state, the cycle after the last byte has been read returns the receive side to open with both addresses at 2.
- R11: `int_st` equals `int_raw` AND `int_ena`, and `irq` is the OR of `int_st`. A 1 in `int_clr` clears the matching raw bit, but an event in the same cycle wins.
- R12: A synchronous active-high `rst` gives `tx_free`=1, `rx_avail`=0, both states 0, transmit addresses 0, receive addresses 2 and all raw bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Push one transmit byte |
| cpu_wdata | input | 32 | Data word, low byte used |
| cpu_done | input | 1 | Commit loaded bytes as a packet |
| cpu_rd | input | 1 | Pop one receive byte |
| cpu_rdata | output | 8 | Oldest unread receive byte, 0 when none |
| tx_free | output | 1 | Transmit buffer accepts writes |
| rx_avail | output | 1 | Receive buffer holds unread bytes |
| in_valid | output | 1 | Transmit stream beat valid |
| in_ready | input | 1 | Transmit stream accepted by engine |
| in_data | output | 8 | Transmit stream byte |
| in_last | output | 1 | Final beat of the transmit packet |
| in_zlp | output | 1 | Beat stands for a zero-length packet |
| out_valid | input | 1 | Receive stream beat valid |
| out_ready | output | 1 | Receive stream can take a beat |
| out_data | input | 8 | Receive stream byte |
| out_last | input | 1 | Final beat of the receive packet |
| out_zlp | input | 1 | Beat carries no byte |
| int_ena | input | 3 | Interrupt enables (bit 0 received, 1 drained, 2 zero payload) |
| int_clr | input | 3 | Raw interrupt clear pulses |
| int_raw | output | 3 | Raw interrupt bits |
| int_st | output | 3 | Masked interrupt status |
| irq | output | 1 | Any status bit set |
| tx_state | output | 2 | Transmit state (0 open, 2 committed) |
| tx_wr_addr | output | AW (7) | Transmit bytes loaded |
| tx_rd_addr | output | AW (7) | Transmit bytes sent |
| rx_state | output | 2 | Receive state (0 open, 1 filling, 2 held) |
| rx_wr_addr | output | AW (7) | Receive write address, 2 plus bytes stored |
| rx_rd_addr | output | AW (7) | Receive read address, 2 plus bytes popped |

## Verification
The transmit path is driven with short packets whose last write coincides with the commit, with an empty commit, and with a packet pushed past full. Together these separate the same-cycle commit rule, the zero-length beat and the ignored overflow. Transmit draining alternates ready to expose any drift of data under stall. The receive path gets gapped packets read while still filling, a zero-payload packet, an oversized packet and beats offered while held, which separate the offset count, the discard rule and the held back-pressure. A long mixed random phase, with clear pulses colliding with events, checks every output on every clock against a behavioural queue model.

// File: rtl/ser_ep_pkg.sv
package ser_ep_pkg;
  typedef enum logic [1:0] {
    EP_OPEN  = 2'd0,
    EP_FILL  = 2'd1,
    EP_READY = 2'd2
  } ep_state_e;

  localparam int IRQ_N        = 3;
  localparam int IRQ_RX_PKT   = 0;
  localparam int IRQ_TX_EMPTY = 1;
  localparam int IRQ_RX_ZLP   = 2;
  localparam int RX_BASE      = 2;
endpackage

// File: rtl/ser_tx_path.sv
module ser_tx_path
  import ser_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          commit,
  input  logic          in_ready,
  output logic          tx_free,
  output logic          in_valid,
  output logic [7:0]    in_data,
  output logic          in_last,
  output logic          in_zlp,
  output logic          drained,
  output logic [1:0]    state,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW-1:0] FULL_A = AW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  ep_state_e     st;
  logic          push;

  assign tx_free  = (st == EP_OPEN) && (wr_ptr < FULL_A);
  assign push     = tx_free && wr_en;
  assign in_valid = (st == EP_READY);
  assign in_zlp   = in_valid && (wr_ptr == '0);
  assign in_last  = in_valid && (in_zlp || (rd_ptr == wr_ptr - 1'b1));
  assign in_data  = (in_valid && !in_zlp) ? mem[IW'(rd_ptr)] : 8'd0;
  assign drained  = in_valid && in_ready && in_last;
  assign state    = st;
  assign wr_addr  = wr_ptr;
  assign rd_addr  = rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[IW'(wr_ptr)] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= EP_OPEN;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      unique case (st)
        EP_OPEN: begin
          if (push) wr_ptr <= wr_ptr + 1'b1;
          if (commit) st <= EP_READY;
        end
        EP_READY: begin
          if (in_ready) begin
            if (in_last) begin
              st     <= EP_OPEN;
              wr_ptr <= '0;
              rd_ptr <= '0;
            end else begin
              rd_ptr <= rd_ptr + 1'b1;
            end
          end
        end
        default: st <= EP_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/ser_rx_path.sv
module ser_rx_path
  import ser_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_valid,
  input  logic [7:0]    out_data,
  input  logic          out_last,
  input  logic          out_zlp,
  input  logic          rd_pop,
  output logic          out_ready,
  output logic          rx_avail,
  output logic [7:0]    rd_byte,
  output logic          pkt_done,
  output logic          zlp_done,
  output logic [1:0]    state,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW-1:0] BASE_A = AW'(RX_BASE);
  localparam logic [AW-1:0] TOP_A  = AW'(DEPTH + RX_BASE);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_next;
  ep_state_e     st;
  logic          beat, store, room;

  assign room      = wr_ptr < TOP_A;
  assign out_ready = (st == EP_OPEN) || (st == EP_FILL);
  assign beat      = out_valid && out_ready;
  assign store     = beat && !out_zlp && room;
  assign wr_next   = store ? wr_ptr + 1'b1 : wr_ptr;
  assign rx_avail  = (rd_ptr != wr_ptr);
  assign rd_byte   = rx_avail ? mem[IW'(rd_ptr - BASE_A)] : 8'd0;
  assign pkt_done  = beat && out_last && (wr_next != BASE_A);
  assign zlp_done  = beat && out_last && (wr_next == BASE_A);
  assign state     = st;
  assign wr_addr   = wr_ptr;
  assign rd_addr   = rd_ptr;

  always_ff @(posedge clk) begin
    if (store) mem[IW'(wr_ptr - BASE_A)] <= out_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= EP_OPEN;
      wr_ptr <= BASE_A;
      rd_ptr <= BASE_A;
    end else begin
      if (rd_pop && rx_avail) rd_ptr <= rd_ptr + 1'b1;
      unique case (st)
        EP_OPEN, EP_FILL: begin
          if (beat) begin
            wr_ptr <= wr_next;
            if (!out_last)            st <= EP_FILL;
            else if (wr_next == BASE_A) st <= EP_OPEN;
            else                      st <= EP_READY;
          end
        end
        EP_READY: begin
          if (!rx_avail) begin
            st     <= EP_OPEN;
            wr_ptr <= BASE_A;
            rd_ptr <= BASE_A;
          end
        end
        default: st <= EP_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/ser_irq_bank.sv
module ser_irq_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ena,
  output logic [N-1:0] raw,
  output logic [N-1:0] st,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)         raw[g] <= 1'b0;
      else if (set[g]) raw[g] <= 1'b1;
      else if (clr[g]) raw[g] <= 1'b0;
    end
    assign st[g] = raw[g] & ena[g];
  end
  assign irq = |st;
endmodule

// File: rtl/ser_ep_buffer.sv
module ser_ep_buffer
  import ser_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [31:0]      cpu_wdata,
  input  logic             cpu_done,
  input  logic             cpu_rd,
  output logic [7:0]       cpu_rdata,
  output logic             tx_free,
  output logic             rx_avail,
  output logic             in_valid,
  input  logic             in_ready,
  output logic [7:0]       in_data,
  output logic             in_last,
  output logic             in_zlp,
  input  logic             out_valid,
  output logic             out_ready,
  input  logic [7:0]       out_data,
  input  logic             out_last,
  input  logic             out_zlp,
  input  logic [IRQ_N-1:0] int_ena,
  input  logic [IRQ_N-1:0] int_clr,
  output logic [IRQ_N-1:0] int_raw,
  output logic [IRQ_N-1:0] int_st,
  output logic             irq,
  output logic [1:0]       tx_state,
  output logic [AW-1:0]    tx_wr_addr,
  output logic [AW-1:0]    tx_rd_addr,
  output logic [1:0]       rx_state,
  output logic [AW-1:0]    rx_wr_addr,
  output logic [AW-1:0]    rx_rd_addr
);
  logic             tx_drained, rx_pkt, rx_zlp;
  logic [IRQ_N-1:0] events;
  logic [23:0]      unused_wdata_hi;

  assign unused_wdata_hi = cpu_wdata[31:8];

  ser_tx_path #(.DEPTH(DEPTH), .AW(AW)) i_tx (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .wr_byte(cpu_wdata[7:0]),
    .commit(cpu_done), .in_ready(in_ready), .tx_free(tx_free),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_zlp(in_zlp), .drained(tx_drained), .state(tx_state),
    .wr_addr(tx_wr_addr), .rd_addr(tx_rd_addr)
  );

  ser_rx_path #(.DEPTH(DEPTH), .AW(AW)) i_rx (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_zlp(out_zlp), .rd_pop(cpu_rd),
    .out_ready(out_ready), .rx_avail(rx_avail), .rd_byte(cpu_rdata),
    .pkt_done(rx_pkt), .zlp_done(rx_zlp), .state(rx_state),
    .wr_addr(rx_wr_addr), .rd_addr(rx_rd_addr)
  );

  always_comb begin
    events               = '0;
    events[IRQ_RX_PKT]   = rx_pkt;
    events[IRQ_TX_EMPTY] = tx_drained;
    events[IRQ_RX_ZLP]   = rx_zlp;
  end

  ser_irq_bank #(.N(IRQ_N)) i_irq (
    .clk(clk), .rst(rst), .set(events), .clr(int_clr), .ena(int_ena),
    .raw(int_raw), .st(int_st), .irq(irq)
  );
endmodule

// File: rtl/ser_ep_buffer_chk.sv
module ser_ep_buffer_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_free,
  input logic          rx_avail,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          in_last,
  input logic          in_zlp,
  input logic          out_ready,
  input logic [7:0]    cpu_rdata,
  input logic [2:0]    int_raw,
  input logic          irq,
  input logic [1:0]    rx_state,
  input logic [AW-1:0] rx_wr_addr,
  input logic [AW-1:0] rx_rd_addr
);
  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_last) && $stable(in_zlp)));

  a_r2_closed_while_sent: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !tx_free);

  a_r4_zlp_single_beat: assert property (@(posedge clk) disable iff (rst)
    in_zlp |-> (in_valid && in_last && in_data == 8'd0));

  a_r6_held_blocks: assert property (@(posedge clk) disable iff (rst)
    (rx_state == 2'd2) |-> !out_ready);

  a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !rx_avail |-> (cpu_rdata == 8'd0));

  a_r7_count_on_pkt: assert property (@(posedge clk) disable iff (rst)
    $rose(int_raw[0]) |-> (rx_wr_addr > AW'(2)));

  a_r10_rd_not_past_wr: assert property (@(posedge clk) disable iff (rst)
    rx_rd_addr <= rx_wr_addr);

  a_r12_reset_state: assert property (@(posedge clk)
    rst |=> (tx_free && !rx_avail && int_raw == 3'd0 && !irq));
endmodule

bind ser_ep_buffer ser_ep_buffer_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .tx_free(tx_free), .rx_avail(rx_avail),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .in_last(in_last), .in_zlp(in_zlp), .out_ready(out_ready),
  .cpu_rdata(cpu_rdata), .int_raw(int_raw), .irq(irq),
  .rx_state(rx_state), .rx_wr_addr(rx_wr_addr), .rx_rd_addr(rx_rd_addr)
);

// File: tb/test_ser_ep_buffer.sv
`timescale 1ns/1ps
module test_ser_ep_buffer;
  localparam int D = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_wr = 0, cpu_done = 0, cpu_rd = 0;
  logic [31:0] cpu_wdata = 0;
  logic in_ready = 0, out_valid = 0, out_last = 0, out_zlp = 0;
  logic [7:0] out_data = 0;
  logic [2:0] int_ena = 0, int_clr = 0;
  logic [7:0] cpu_rdata, in_data;
  logic tx_free, rx_avail, in_valid, in_last, in_zlp, out_ready, irq;
  logic [2:0] int_raw, int_st;
  logic [1:0] tx_state, rx_state;
  logic [6:0] tx_wr_addr, tx_rd_addr, rx_wr_addr, rx_rd_addr;

  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  ser_ep_buffer i_ser_ep_buffer (.*);

  // behavioural reference model
  byte unsigned m_tx[D];
  byte unsigned m_rx[$];
  int  m_tx_n, m_tx_r, m_rx_w, m_rx_r, m_rx_mode;
  bit  m_sent;
  bit [2:0] m_raw;

  function automatic bit e_tx_last();
    return m_sent && (m_tx_n == 0 || m_tx_r == m_tx_n - 1);
  endfunction

  function automatic bit e_out_ready();
    return m_rx_mode != 2;
  endfunction

  always @(posedge clk) begin
    bit lst, avail, rdy;
    bit [2:0] ev;
    if (rst) begin
      m_tx_n = 0; m_tx_r = 0; m_sent = 0;
      m_rx.delete(); m_rx_w = 0; m_rx_r = 0; m_rx_mode = 0; m_raw = 0;
    end else begin
      ev = 0;
      lst = e_tx_last();
      avail = m_rx_r < m_rx_w;
      rdy = e_out_ready();
      if (!m_sent) begin
        if (cpu_wr && m_tx_n < D) begin m_tx[m_tx_n] = cpu_wdata[7:0]; m_tx_n++; end
        if (cpu_done) m_sent = 1;
      end else if (in_ready) begin
        if (lst) begin m_sent = 0; m_tx_n = 0; m_tx_r = 0; ev[1] = 1; end
        else m_tx_r++;
      end
      if (cpu_rd && avail) m_rx_r++;
      if (m_rx_mode == 2) begin
        if (!avail) begin m_rx_mode = 0; m_rx_w = 0; m_rx_r = 0; m_rx.delete(); end
      end else if (out_valid && rdy) begin
        if (!out_zlp && m_rx_w < D) begin m_rx.push_back(out_data); m_rx_w++; end
        if (!out_last) m_rx_mode = 1;
        else if (m_rx_w == 0) begin m_rx_mode = 0; ev[2] = 1; end
        else begin m_rx_mode = 2; ev[0] = 1; end
      end
      m_raw = (m_raw & ~int_clr) | ev;
    end
  end

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_data, e_rd;
    e_data = (m_sent && m_tx_n != 0) ? m_tx[m_tx_r] : 8'd0;
    e_rd   = (m_rx_r < m_rx_w) ? m_rx[m_rx_r] : 8'd0;
    chk("R1",  "tx_free",    tx_free,    !m_sent && m_tx_n < D);
    chk("R1",  "tx_wr_addr", tx_wr_addr, m_tx_n);
    chk("R2",  "tx_state",   tx_state,   m_sent ? 2 : 0);
    chk("R3",  "in_valid",   in_valid,   m_sent);
    chk("R3",  "in_data",    in_data,    e_data);
    chk("R3",  "in_last",    in_last,    e_tx_last());
    chk("R3",  "tx_rd_addr", tx_rd_addr, m_tx_r);
    chk("R4",  "in_zlp",     in_zlp,     m_sent && m_tx_n == 0);
    chk("R5",  "raw_drain",  int_raw[1], m_raw[1]);
    chk("R6",  "out_ready",  out_ready,  e_out_ready());
    chk("R7",  "rx_wr_addr", rx_wr_addr, m_rx_w + 2);
    chk("R7",  "raw_pkt",    int_raw[0], m_raw[0]);
    chk("R8",  "raw_zlp",    int_raw[2], m_raw[2]);
    chk("R9",  "rx_avail",   rx_avail,   m_rx_r < m_rx_w);
    chk("R9",  "cpu_rdata",  cpu_rdata,  e_rd);
    chk("R9",  "rx_rd_addr", rx_rd_addr, m_rx_r + 2);
    chk("R10", "rx_state",   rx_state,   m_rx_mode);
    chk("R11", "int_st",     int_st,     m_raw & int_ena);
    chk("R11", "irq",        irq,        |(m_raw & int_ena));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
    cpu_wr = 0; cpu_done = 0; cpu_rd = 0; in_ready = 0;
    out_valid = 0; out_last = 0; out_zlp = 0; int_clr = 0;
  endtask

  task automatic reset_check();
    rst = 1; cyc(); rst = 0;
    chk("R12", "tx_free",    tx_free, 1);
    chk("R12", "rx_avail",   rx_avail, 0);
    chk("R12", "int_raw",    int_raw, 0);
    chk("R12", "rx_wr_addr", rx_wr_addr, 2);
    chk("R12", "tx_wr_addr", tx_wr_addr, 0);
    chk("R12", "states",     {tx_state, rx_state}, 0);
  endtask

  task automatic rx_byte(input logic [7:0] b, input bit last);
    out_valid = 1; out_data = b; out_last = last; cyc();
  endtask

  initial begin
    cyc(); cyc();
    reset_check();
    int_ena = 3'b111;

    // R1 R2 R3 R5: three bytes, last one written with the commit, drained with stalls
    cpu_wr = 1; cpu_wdata = 32'hFFFF_FFA1; cyc();
    cpu_wr = 1; cpu_wdata = 32'h1234_56B2; cyc();
    cpu_wr = 1; cpu_wdata = 32'h0000_00C3; cpu_done = 1; cyc();
    chk("R2", "committed_count", tx_wr_addr, 3);
    for (int i = 0; i < 10; i++) begin in_ready = i[0]; cyc(); end
    chk("R5", "drain_raw", int_raw[1], 1);
    int_clr = 3'b010; cyc();
    chk("R11", "clear_raw", int_raw[1], 0);

    // R4: empty commit, stalled then accepted
    cpu_done = 1; cyc();
    cyc(); cyc();
    in_ready = 1; cyc(); cyc();

    // R1 R2: overfill, same-cycle write during commit, writes while committed
    for (int i = 0; i < D + 2; i++) begin cpu_wr = 1; cpu_wdata = 32'h100 + i; cyc(); end
    chk("R1", "full_not_free", tx_free, 0);
    cpu_done = 1; cyc();
    for (int i = 0; i < 3; i++) begin cpu_wr = 1; cpu_done = 1; cpu_wdata = 32'h55; cyc(); end
    for (int i = 0; i < D + 4; i++) begin in_ready = 1; int_clr = (i == D - 1) ? 3'b010 : 3'b000; cyc(); end

    // R6 R7 R9 R10: gapped packet read while filling, then stalls while held
    cpu_rd = 1; cyc();
    rx_byte(8'h11, 0); cyc();
    rx_byte(8'h22, 0); cpu_rd = 1; cyc();
    rx_byte(8'h33, 0); rx_byte(8'h44, 0); rx_byte(8'h55, 1);
    chk("R7", "count_offset", rx_wr_addr, 7);
    for (int i = 0; i < 3; i++) rx_byte(8'hEE, 1);
    for (int i = 0; i < 7; i++) begin cpu_rd = 1; cyc(); end
    cyc();
    chk("R10", "reopened", rx_wr_addr, 2);

    // R8: zero-payload packet, R11 masking
    int_ena = 3'b011;
    out_valid = 1; out_zlp = 1; out_last = 1; cyc();
    chk("R8", "zlp_raw", int_raw[2], 1);
    chk("R11", "masked", int_st[2], 0);
    int_ena = 3'b111; int_clr = 3'b111; cyc();

    // R6: oversized packet keeps only the first DEPTH bytes
    for (int i = 0; i < D + 2; i++) rx_byte(8'(i * 7 + 1), i == D + 1);
    chk("R6", "clipped", rx_wr_addr, D + 2);
    for (int i = 0; i < D + 2; i++) begin cpu_rd = 1; cyc(); end

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      cpu_wr    = ($urandom_range(0, 1) == 1);
      cpu_wdata = $urandom;
      cpu_done  = ($urandom_range(0, 19) == 0);
      in_ready  = ($urandom_range(0, 4) < 3);
      out_valid = ($urandom_range(0, 1) == 1);
      out_data  = 8'($urandom);
      out_last  = ($urandom_range(0, 7) == 0);
      out_zlp   = ($urandom_range(0, 7) == 0);
      cpu_rd    = ($urandom_range(0, 4) < 2);
      int_clr   = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000;
      if ($urandom_range(0, 49) == 0) int_ena = 3'($urandom);
      cyc();
    end

    reset_check();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule